// File: doc/BRIEF.md
# Inclusive Last-Level Cache Snoop Filter

This block is the coherence directory that sits beside a shared, inclusive last-level cache serving four cores. For every line the shared cache holds, it keeps a tag, a presence vector with one bit per core, the coherence state of the private copies, and the identity of the core that supplies data. When a core misses in its private cache, the block works out which other cores must be snooped. It uses the presence vector to skip any core that certainly holds no copy.

A clear presence bit is a guarantee: that core has no copy. A set bit is only a hint, because a core may drop a clean line without saying so. Snoops therefore come back as hit or miss, and a miss clears the stale bit. The state set is invalid, shared, exclusive, modified and forward. Exactly one reader is named as the forwarder of a clean shared line, and that role moves to each new reader.

The block also updates the directory in four other cases: when a core takes ownership, when a core writes back a modified line, when the shared cache evicts a line, and when a new line displaces an older one from its set. In the last two cases the block sends back-invalidates to every core whose bit is set, so that inclusion holds. Requests are served one at a time. A busy flag holds off further requests until every snooped core has answered. The directory is direct mapped on the low line-address bits.

Top module: `snoop_filter`

## Requirements
- R1: After reset, `busy`, `snp_valid` and `rsp_valid` are low and the directory is empty, so the first read of any line issues no snoop.
- R2: A read (`req_op`=0) of a line that no other core's bit marks issues no snoop. The requester gets exclusive state (`rsp_state`=2) with `rsp_snooped`=0.
- R3: A read of a tracked line snoops exactly the presence vector with the requester's bit removed, with `snp_inval`=0 and `snp_addr` equal to the requested address.
- R4: On a read snoop, `snp_fwd` is the one-hot bit of the recorded supplier when the line is exclusive, modified or forward and that supplier is in the snoop mask; otherwise it is 0. If another core still holds the line, the reader gets forward state (`rsp_state`=4) and becomes the supplier.
- R5: A snooped core that answers a read snoop with `snp_hit` low loses its presence bit. If no other core remains, the reader gets exclusive state.
- R6: A read-for-ownership (`req_op`=1) snoops every other core whose bit is set, with `snp_inval`=1. Afterwards only the requester's bit is set, and it gets modified state (`rsp_state`=3).
- R7: A modified writeback (`req_op`=2) issues no snoop and clears the writer's bit. The reported state is invalid (0) if no bit remains. Otherwise it is shared (1) if the writer was the supplier, and unchanged if it was not.
- R8: A shared-cache eviction (`req_op`=3) of a tracked line back-invalidates all cores with set bits (`snp_inval`=1, `snp_fwd`=0) and removes the line. Evicting an untracked line issues no snoop. Both cases report state invalid.
- R9: A read or read-for-ownership that finds its set holding a different tag with any bit set first back-invalidates those cores at the victim's address (`snp_inval`=1). It then installs the new line for the requester.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the response cycle, in which it is low. Requests presented while `busy` is high are ignored. Snoop answers may arrive one per core, in any order.
- R11: Each request gets exactly one single-cycle `rsp_valid` pulse. `rsp_state` is encoded invalid=0, shared=1, exclusive=2, modified=3, forward=4. `rsp_dirty` is 1 when any snooped core answered with `snp_dirty` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 read, 1 read-for-ownership, 2 modified writeback, 3 shared-cache eviction |
| req_core | input | 2 | Requesting core |
| req_addr | input | 12 | Line address (low 4 bits select the set) |
| busy | output | 1 | A request is in progress |
| snp_valid | output | 1 | Snoop issue pulse |
| snp_addr | output | 12 | Line address being snooped |
| snp_mask | output | 4 | Cores to snoop |
| snp_inval | output | 1 | Snooped cores must invalidate |
| snp_fwd | output | 4 | One-hot core asked to supply data |
| snp_ack | input | 4 | Per-core snoop answer strobe |
| snp_hit | input | 4 | Per-core: the line was present |
| snp_dirty | input | 4 | Per-core: modified data returned |
| rsp_valid | output | 1 | Response pulse |
| rsp_state | output | 3 | Resulting state for the request |
| rsp_snooped | output | 1 | At least one core was snooped |
| rsp_dirty | output | 1 | Modified data came back from a snoop |

## Verification
Two functions can land in one request: inclusion maintenance and a new request's own fill. A read or ownership request to a set that holds another line must back-invalidate the victim, at the victim's address, before the new line is installed. The bench sets this up by mixing three tags within two sets during a long pseudo-random sweep, alongside directed conflict cases. It judges the snoop address, mask and invalidate flag against a directory model kept in the bench. The same sweep also lets stale-bit pruning and forward hand-off happen together in one read, and checks the resulting state on the response.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_M = 3'd3,
    LS_F = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_RFO   = 2'd1,
    OP_WB    = 2'd2,
    OP_EVICT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LOOK = 2'd1,
    FS_WAIT = 2'd2,
    FS_DONE = 2'd3
  } fsm_e;
endpackage

// File: rtl/sf_dir_ram.sv
module sf_dir_ram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

  // Lookup and update never share a cycle: one request at a time
  assert_port_exclusive_R10: assert property (@(posedge clk) !(we && re));
endmodule

// File: rtl/sf_snoop_plan.sv
module sf_snoop_plan
  import sf_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TAG_W     = 8,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  op_e                  op,
  input  logic [CORE_W-1:0]    core,
  input  logic [TAG_W-1:0]     req_tag,
  input  logic                 ent_vld,
  input  logic [TAG_W-1:0]     ent_tag,
  input  logic [NUM_CORES-1:0] ent_cv,
  input  line_st_e             ent_st,
  input  logic [CORE_W-1:0]    ent_sup,
  output logic                 hit,
  output logic                 victim,
  output logic [NUM_CORES-1:0] mask,
  output logic                 inval,
  output logic [NUM_CORES-1:0] fwd
);
  logic [NUM_CORES-1:0] own;
  logic [NUM_CORES-1:0] sup_bit;
  logic                 fill_op;
  logic                 supplier_state;

  always_comb begin
    own          = '0;
    own[core]    = 1'b1;
    sup_bit      = '0;
    sup_bit[ent_sup] = 1'b1;
    fill_op      = (op == OP_RD) || (op == OP_RFO);
    hit          = ent_vld && (ent_tag == req_tag);
    victim       = fill_op && ent_vld && !hit && (ent_cv != '0);
    supplier_state = (ent_st == LS_E) || (ent_st == LS_M) || (ent_st == LS_F);

    mask = '0;
    if (fill_op && hit)          mask = ent_cv & ~own;
    else if (victim)             mask = ent_cv;
    else if (op == OP_EVICT && hit) mask = ent_cv;

    inval = (op != OP_RD) || victim;

    fwd = '0;
    if (op == OP_RD && hit && supplier_state) fwd = sup_bit & mask;
  end
endmodule

// File: rtl/sf_snoop_tracker.sv
module sf_snoop_tracker #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [NUM_CORES-1:0] load_mask,
  input  logic [NUM_CORES-1:0] ack,
  input  logic [NUM_CORES-1:0] hit,
  input  logic [NUM_CORES-1:0] dirty,
  output logic [NUM_CORES-1:0] pend,
  output logic [NUM_CORES-1:0] hit_acc,
  output logic                 dirty_acc,
  output logic                 drained
);
  logic [NUM_CORES-1:0] take;

  always_comb begin
    take    = ack & pend;
    drained = ((pend & ~ack) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      hit_acc   <= '0;
      dirty_acc <= 1'b0;
    end else if (load) begin
      pend      <= load_mask;
      hit_acc   <= '0;
      dirty_acc <= 1'b0;
    end else begin
      pend      <= pend & ~ack;
      hit_acc   <= hit_acc | (take & hit);
      dirty_acc <= dirty_acc | (|(take & dirty));
    end
  end

  // A new snoop set is only loaded once every earlier answer is in
  assert_reload_idle_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> (pend == '0));
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import sf_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12,
  parameter int SET_W     = 4,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [CORE_W-1:0]    req_core,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 busy,
  output logic                 snp_valid,
  output logic [ADDR_W-1:0]    snp_addr,
  output logic [NUM_CORES-1:0] snp_mask,
  output logic                 snp_inval,
  output logic [NUM_CORES-1:0] snp_fwd,
  input  logic [NUM_CORES-1:0] snp_ack,
  input  logic [NUM_CORES-1:0] snp_hit,
  input  logic [NUM_CORES-1:0] snp_dirty,
  output logic                 rsp_valid,
  output logic [2:0]           rsp_state,
  output logic                 rsp_snooped,
  output logic                 rsp_dirty
);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int ST_W  = 3;
  localparam int DW    = TAG_W + NUM_CORES + ST_W + CORE_W;
  localparam int SETS  = 1 << SET_W;

  fsm_e                 fs, fs_nxt;
  op_e                  op_r;
  logic [CORE_W-1:0]    core_r;
  logic [ADDR_W-1:0]    addr_r;
  logic                 vld_r;
  logic                 hit_r;
  logic [NUM_CORES-1:0] mask_r;
  logic [SETS-1:0]      present;

  logic [SET_W-1:0]     idx_r;
  logic [TAG_W-1:0]     tag_r;
  logic [NUM_CORES-1:0] own_r;

  logic [DW-1:0]        ram_q, ram_wdata;
  logic                 ram_re, ram_we;
  logic [TAG_W-1:0]     q_tag;
  logic [NUM_CORES-1:0] q_cv;
  logic [ST_W-1:0]      q_st_raw;
  line_st_e             q_st;
  logic [CORE_W-1:0]    q_sup;

  logic                 p_hit, p_victim, p_inval;
  logic [NUM_CORES-1:0] p_mask, p_fwd;

  logic                 trk_load, trk_drained, trk_dirty;
  logic [NUM_CORES-1:0] trk_pend, trk_hit;

  logic [NUM_CORES-1:0] cv_live, others, w_cv;
  line_st_e             w_st;
  logic [CORE_W-1:0]    w_sup;
  logic [TAG_W-1:0]     w_tag;
  logic                 w_en;

  always_comb begin
    idx_r        = addr_r[SET_W-1:0];
    tag_r        = addr_r[ADDR_W-1:SET_W];
    own_r        = '0;
    own_r[core_r] = 1'b1;
    {q_tag, q_cv, q_st_raw, q_sup} = ram_q;
    q_st         = line_st_e'(q_st_raw);
    ram_re       = (fs == FS_IDLE) && req_valid;
    trk_load     = (fs == FS_LOOK);
  end

  sf_dir_ram #(.DW(DW), .AW(SET_W)) u_ram (
    .clk   (clk),
    .re    (ram_re),
    .raddr (req_addr[SET_W-1:0]),
    .q     (ram_q),
    .we    (ram_we),
    .waddr (idx_r),
    .wdata (ram_wdata)
  );

  sf_snoop_plan #(.NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_plan (
    .op      (op_r),
    .core    (core_r),
    .req_tag (tag_r),
    .ent_vld (vld_r),
    .ent_tag (q_tag),
    .ent_cv  (q_cv),
    .ent_st  (q_st),
    .ent_sup (q_sup),
    .hit     (p_hit),
    .victim  (p_victim),
    .mask    (p_mask),
    .inval   (p_inval),
    .fwd     (p_fwd)
  );

  sf_snoop_tracker #(.NUM_CORES(NUM_CORES)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .load      (trk_load),
    .load_mask (p_mask),
    .ack       (snp_ack),
    .hit       (snp_hit),
    .dirty     (snp_dirty),
    .pend      (trk_pend),
    .hit_acc   (trk_hit),
    .dirty_acc (trk_dirty),
    .drained   (trk_drained)
  );

  // Directory update computed for the completion cycle
  always_comb begin
    cv_live = q_cv & ~(mask_r & ~trk_hit);
    others  = cv_live & ~own_r;
    w_cv    = q_cv;
    w_st    = LS_I;
    w_sup   = q_sup;
    w_tag   = q_tag;
    w_en    = 1'b0;
    unique case (op_r)
      OP_RD: begin
        w_en  = 1'b1;
        w_tag = tag_r;
        w_sup = core_r;
        if (hit_r) begin
          w_cv = cv_live | own_r;
          w_st = (others != '0) ? LS_F : LS_E;
        end else begin
          w_cv = own_r;
          w_st = LS_E;
        end
      end
      OP_RFO: begin
        w_en  = 1'b1;
        w_tag = tag_r;
        w_sup = core_r;
        w_cv  = own_r;
        w_st  = LS_M;
      end
      OP_WB: begin
        if (hit_r) begin
          w_en = 1'b1;
          w_cv = q_cv & ~own_r;
          if (w_cv == '0)          w_st = LS_I;
          else if (q_sup == core_r) w_st = LS_S;
          else                     w_st = q_st;
        end
      end
      default: begin
        w_st = LS_I;
      end
    endcase
    ram_we    = (fs == FS_DONE) && w_en;
    ram_wdata = {w_tag, w_cv, ST_W'(w_st), w_sup};
  end

  always_comb begin
    fs_nxt = fs;
    unique case (fs)
      FS_IDLE: if (req_valid) fs_nxt = FS_LOOK;
      FS_LOOK: fs_nxt = (p_mask != '0) ? FS_WAIT : FS_DONE;
      FS_WAIT: if (trk_drained) fs_nxt = FS_DONE;
      default: fs_nxt = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs          <= FS_IDLE;
      busy        <= 1'b0;
      present     <= '0;
      op_r        <= OP_RD;
      core_r      <= '0;
      addr_r      <= '0;
      vld_r       <= 1'b0;
      hit_r       <= 1'b0;
      mask_r      <= '0;
      snp_valid   <= 1'b0;
      snp_addr    <= '0;
      snp_mask    <= '0;
      snp_inval   <= 1'b0;
      snp_fwd     <= '0;
      rsp_valid   <= 1'b0;
      rsp_state   <= '0;
      rsp_snooped <= 1'b0;
      rsp_dirty   <= 1'b0;
    end else begin
      fs        <= fs_nxt;
      busy      <= (fs_nxt != FS_IDLE);
      snp_valid <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (fs)
        FS_IDLE: begin
          if (req_valid) begin
            op_r   <= op_e'(req_op);
            core_r <= req_core;
            addr_r <= req_addr;
            vld_r  <= present[req_addr[SET_W-1:0]];
          end
        end
        FS_LOOK: begin
          hit_r  <= p_hit;
          mask_r <= p_mask;
          if (p_mask != '0) begin
            snp_valid <= 1'b1;
            snp_mask  <= p_mask;
            snp_inval <= p_inval;
            snp_fwd   <= p_fwd;
            snp_addr  <= p_victim ? {q_tag, idx_r} : addr_r;
          end
        end
        FS_DONE: begin
          rsp_valid   <= 1'b1;
          rsp_state   <= ST_W'(w_st);
          rsp_snooped <= (mask_r != '0);
          rsp_dirty   <= trk_dirty;
          if (op_r == OP_RD || op_r == OP_RFO) present[idx_r] <= 1'b1;
          else if (op_r == OP_EVICT && hit_r) present[idx_r] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // A non-invalidating read snoop never targets the requester
  assert_no_self_snoop_R3: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !snp_inval) |-> ((snp_mask & own_r) == '0));

  // At most one supplier, and it is among the snooped cores
  assert_single_supplier_R4: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> ($onehot0(snp_fwd) && ((snp_fwd & ~snp_mask) == '0)));

  // Back-invalidates and ownership snoops never name a supplier
  assert_inval_no_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_inval) |-> (snp_fwd == '0));

  assert_snoop_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> busy);

  assert_rsp_frees_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_state_code_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_state <= 3'd4));
endmodule

// File: tb/snoop_filter_test.sv
`timescale 1ns/1ps
module snoop_filter_test;
  localparam int NC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [1:0] req_core = '0;
  logic [11:0] req_addr = '0;
  logic       busy, snp_valid, snp_inval, rsp_valid, rsp_snooped, rsp_dirty;
  logic [11:0] snp_addr;
  logic [3:0] snp_mask, snp_fwd;
  logic [3:0] snp_ack = '0, snp_hit = '0, snp_dirty = '0;
  logic [2:0] rsp_state;

  int nchk = 0, nfail = 0;
  int cyc = 0;

  // bench directory model, 16 sets
  bit       m_val [16];
  int       m_tag [16];
  bit [3:0] m_cv  [16];
  int       m_st  [16];
  int       m_sup [16];

  always #4 clk = ~clk;  // 125 MHz

  snoop_filter uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_core(req_core), .req_addr(req_addr), .busy(busy),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_mask(snp_mask),
    .snp_inval(snp_inval), .snp_fwd(snp_fwd), .snp_ack(snp_ack),
    .snp_hit(snp_hit), .snp_dirty(snp_dirty), .rsp_valid(rsp_valid),
    .rsp_state(rsp_state), .rsp_snooped(rsp_snooped), .rsp_dirty(rsp_dirty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input int op, input int c, input int a,
                       input bit [3:0] hp, input bit [3:0] dp, input string rtag);
    int idx, tg, e_st, e_saddr;
    bit hit, victim, e_inval, seen_snp, got, busy_bad;
    bit [3:0] own, e_mask, e_fwd, live, oth;
    string stag;
    idx = a & 15; tg = a >> 4;
    own = 4'(1 << c);
    hit = m_val[idx] && (m_tag[idx] == tg);
    victim = (op <= 1) && m_val[idx] && !hit && (m_cv[idx] != 0);
    e_mask = 0; e_inval = (op != 0) || victim; e_fwd = 0; e_saddr = a;
    stag = "R3";
    if (op <= 1 && hit) begin
      e_mask = m_cv[idx] & ~own;
      stag = (op == 1) ? "R6" : "R3";
      if (op == 0 && (m_st[idx] >= 2) && e_mask[m_sup[idx]])
        e_fwd = 4'(1 << m_sup[idx]);
    end else if (victim) begin
      e_mask = m_cv[idx]; e_saddr = (m_tag[idx] << 4) | idx; stag = "R9";
    end else if (op == 3 && hit) begin
      e_mask = m_cv[idx]; stag = "R8";
    end

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_core = 2'(c); req_addr = 12'(a);
    @(negedge clk);
    // request presented while busy must be ignored
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    req_op = 2'd1; req_core = 2'((c + 1) % 4); req_addr = 12'(a ^ 12'h010);
    seen_snp = 0; got = 0; busy_bad = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin
        got = 1;
      end else begin
        if (!busy) busy_bad = 1;
        if (snp_valid) begin
          seen_snp = 1;
          chk(snp_mask == e_mask, stag, "snoop mask", snp_mask, e_mask);
          chk(snp_inval == e_inval, stag, "snoop inval", snp_inval, e_inval);
          chk(snp_fwd == e_fwd, "R4", "supplier", snp_fwd, e_fwd);
          chk(snp_addr == 12'(e_saddr), stag, "snoop addr", snp_addr, e_saddr);
          for (int i = NC - 1; i >= 0; i--) begin
            if (e_mask[i]) begin
              snp_ack = 4'(1 << i); snp_hit = hp; snp_dirty = dp & hp;
              @(negedge clk);
              if (!busy && !rsp_valid) busy_bad = 1;
              snp_ack = '0;
            end
          end
        end
      end
    end
    chk(got, "R11", "response seen", got, 1);
    chk(seen_snp == (e_mask != 0), (e_mask == 0) ? "R2" : stag, "snoop issued",
        seen_snp, (e_mask != 0));
    chk(!busy_bad, "R10", "busy held", busy_bad, 0);
    chk(busy == 1'b0, "R10", "busy low at response", busy, 0);

    // model update
    e_st = 0;
    case (op)
      0: begin
        if (hit) begin
          live = m_cv[idx] & ~(e_mask & ~hp);
          oth = live & ~own;
          m_cv[idx] = live | own;
          e_st = (oth != 0) ? 4 : 2;
        end else begin
          m_cv[idx] = own; e_st = 2;
        end
        m_val[idx] = 1; m_tag[idx] = tg; m_sup[idx] = c; m_st[idx] = e_st;
      end
      1: begin
        m_val[idx] = 1; m_tag[idx] = tg; m_sup[idx] = c; m_cv[idx] = own;
        e_st = 3; m_st[idx] = 3;
      end
      2: begin
        if (hit) begin
          m_cv[idx] = m_cv[idx] & ~own;
          if (m_cv[idx] == 0) e_st = 0;
          else if (m_sup[idx] == c) e_st = 1;
          else e_st = m_st[idx];
          m_st[idx] = e_st;
        end
      end
      default: begin
        if (hit) begin m_val[idx] = 0; m_cv[idx] = 0; end
      end
    endcase
    chk(rsp_state == 3'(e_st), rtag, "rsp state", rsp_state, e_st);
    chk(rsp_snooped == (e_mask != 0), "R11", "rsp snooped", rsp_snooped, (e_mask != 0));
    chk(rsp_dirty == (|(e_mask & hp & dp)), "R11", "rsp dirty", rsp_dirty,
        (|(e_mask & hp & dp)));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 0; m_tag[i] = 0; m_cv[i] = 0; m_st[i] = 0; m_sup[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1", "reset busy", busy, 0);
    chk(snp_valid == 0, "R1", "reset snoop", snp_valid, 0);
    chk(rsp_valid == 0, "R1", "reset rsp", rsp_valid, 0);

    do_op(0, 0, 12'h012, 4'hF, 4'h0, "R2");  // empty line: exclusive
    do_op(0, 1, 12'h012, 4'hF, 4'h0, "R4");  // core0 supplies, core1 forward
    do_op(0, 2, 12'h012, 4'hF, 4'h0, "R4");  // forward moves to core2
    do_op(0, 3, 12'h012, 4'h0, 4'h0, "R5");  // all stale: exclusive
    do_op(0, 0, 12'h012, 4'hF, 4'h0, "R4");
    do_op(1, 1, 12'h012, 4'hF, 4'h0, "R6");  // ownership
    do_op(0, 2, 12'h012, 4'hF, 4'hF, "R11"); // dirty data from owner
    do_op(2, 2, 12'h012, 4'hF, 4'h0, "R7");  // supplier writes back: shared
    do_op(0, 3, 12'h012, 4'hF, 4'h0, "R4");
    do_op(2, 0, 12'h012, 4'hF, 4'h0, "R7");  // writeback of untracked core
    do_op(3, 0, 12'h012, 4'hF, 4'h2, "R8");  // back-invalidate
    do_op(3, 0, 12'h012, 4'hF, 4'h0, "R8");  // already gone
    do_op(0, 0, 12'h012, 4'hF, 4'h0, "R2");
    do_op(0, 1, 12'h022, 4'hF, 4'h0, "R9");  // conflict displaces 0x012
    do_op(1, 2, 12'h032, 4'hF, 4'h0, "R9");

    begin
      bit [15:0] lf;
      lf = 16'hACE1;
      for (int n = 0; n < 500; n++) begin
        int op, c, a;
        bit [3:0] hp, dp;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        op = int'(lf[1:0]);
        c  = int'(lf[3:2]);
        a  = ((int'(lf[7:4]) % 3) << 4) | int'(lf[8]);
        hp = (lf[11:9] == 3'd0) ? 4'h0 : lf[15:12] | 4'(lf[9]);
        dp = lf[12:9];
        do_op(op, c, a, hp, dp, "R11");
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule